// File: doc/BRIEF.md
# Domain and Access-Permission Checker

This block decides, in a single combinational pass, whether a memory access that has already hit in the translation cache may go ahead. It takes the cached entry's domain number, its permission bits and mapping kind, together with the virtual address, the direction of the access, the privilege level, two control bits (system protection and ROM protection) and the 32-bit domain access control word. It returns a 2-bit fault code and echoes the domain number it consulted, so that a fault status register elsewhere can record it.

The domain's access field is looked up first. A manager domain skips all permission checks. A client domain picks one 2-bit permission field out of the entry. The virtual address bits that choose this field depend on the page size. The field is then decoded against the privilege level and the two control bits. Nothing is registered: the verdict is valid in the same cycle as the inputs.

Top module: `dap_checker`

## Requirements
- R1: The access field used is bits [2d+1:2d] of `dacr_i`, where d = `dom_i` (0 to 15).
- R2: Access field value 0 or 2 gives `fault_o` = 1 (section domain fault), whatever the permission bits are.
- R3: Access field value 3 (manager) gives `fault_o` = 0 for every permission, direction and privilege.
- R4: With access field 1 (client), the permission slot index is `va_i[11:10]` for `map_i`=0 (small page), `va_i[15:14]` for `map_i`=1 (large page), 3 for `map_i`=2 (section) and 0 for `map_i`=3 (extended small page). The slot's 2-bit AP value is `perm_i[4+2*slot +: 2]`.
- R5: AP=0 allows a read only when (`sys_i`=1 and `user_i`=0) or `rom_i`=1. It never allows a write.
- R6: AP=1 allows any access when `user_i`=0, and denies every user access.
- R7: AP=2 allows every read, and allows writes only when `user_i`=0.
- R8: AP=3 allows every access.
- R9: A denied client access gives `fault_o` = 2 (section permission) when `map_i`=2, and 3 (subpage permission) for any other mapping. An allowed access gives 0.
- R10: `dom_o` always equals `dom_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dom_i | input | 4 | Domain number of the hit entry |
| perm_i | input | 12 | Permission bits of the entry (AP slots at [11:4]) |
| map_i | input | 2 | Mapping kind: 0 small, 1 large, 2 section, 3 extended small |
| va_i | input | 32 | Virtual address of the access |
| rd_i | input | 1 | 1 = read, 0 = write |
| user_i | input | 1 | 1 = unprivileged (user) access |
| sys_i | input | 1 | System protection control bit |
| rom_i | input | 1 | ROM protection control bit |
| dacr_i | input | 32 | Domain access control word, 2 bits per domain |
| fault_o | output | 2 | 0 none, 1 section domain, 2 section permission, 3 subpage permission |
| dom_o | output | 4 | Domain number that was consulted |

## Verification
The block holds no state, so any fault in its logic shows at `fault_o` in the same cycle as the input that exposes it. Nothing is left behind to reveal it later. An error in the field selection appears only for particular domain numbers, address bits or slot indices. The bench therefore walks every domain with a lone field set, and moves distinct AP values through all four slots of every mapping kind. A decode error appears only for a particular combination of direction, privilege and control bits. For that reason every AP value is swept against all sixteen combinations, for each mapping kind.

// File: rtl/dap_pkg.sv
package dap_pkg;
  parameter int unsigned VA_W   = 32;
  parameter int unsigned DOM_W  = 4;
  parameter int unsigned PERM_W = 12;
  parameter int unsigned FLD_W  = 2;
  localparam int unsigned NUM_DOM = 1 << DOM_W;
  localparam int unsigned DACR_W  = NUM_DOM * FLD_W;

  typedef enum logic [1:0] {
    MAP_SMALL   = 2'd0,
    MAP_LARGE   = 2'd1,
    MAP_SECTION = 2'd2,
    MAP_XSMALL  = 2'd3
  } map_e;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_CLIENT  = 2'd1,
    ACC_RSVD    = 2'd2,
    ACC_MANAGER = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'd0,
    FLT_DOMAIN    = 2'd1,
    FLT_SECT_PERM = 2'd2,
    FLT_SUB_PERM  = 2'd3
  } fault_e;
endpackage

// File: rtl/dap_domain_sel.sv
module dap_domain_sel #(
  parameter int unsigned DOM_W = 4,
  parameter int unsigned FLD_W = 2,
  localparam int unsigned NUM_DOM = 1 << DOM_W,
  localparam int unsigned DACR_W  = NUM_DOM * FLD_W
) (
  input  logic [DACR_W-1:0] dacr_i,
  input  logic [DOM_W-1:0]  dom_i,
  output dap_pkg::acc_e     acc_o
);
  logic [FLD_W-1:0] fld [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_fld
    assign fld[g] = dacr_i[g*FLD_W +: FLD_W];
  end

  assign acc_o = dap_pkg::acc_e'(fld[dom_i]);
endmodule

// File: rtl/dap_ap_sel.sv
module dap_ap_sel #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PERM_W    = 12,
  parameter int unsigned AP_W      = 2,
  parameter int unsigned AP_LSB    = 4,
  parameter int unsigned SMALL_LSB = 10,
  parameter int unsigned LARGE_LSB = 14,
  localparam int unsigned SUB_W    = 2,
  localparam int unsigned NUM_SUB  = 1 << SUB_W
) (
  input  logic [PERM_W-1:0] perm_i,
  input  dap_pkg::map_e     map_i,
  input  logic [VA_W-1:0]   va_i,
  output logic [AP_W-1:0]   ap_o
);
  logic [AP_W-1:0]  ap_arr [NUM_SUB];
  logic [SUB_W-1:0] sub;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_slot
    assign ap_arr[g] = perm_i[AP_LSB + g*AP_W +: AP_W];
  end

  always_comb begin
    unique case (map_i)
      dap_pkg::MAP_SMALL:   sub = va_i[SMALL_LSB +: SUB_W];
      dap_pkg::MAP_LARGE:   sub = va_i[LARGE_LSB +: SUB_W];
      dap_pkg::MAP_SECTION: sub = '1;
      default:              sub = '0;
    endcase
  end

  assign ap_o = ap_arr[sub];

  // bits that never pick a slot
  logic unused_bits;
  assign unused_bits = ^{va_i[VA_W-1:LARGE_LSB+SUB_W], va_i[LARGE_LSB-1:SMALL_LSB+SUB_W],
                         va_i[SMALL_LSB-1:0], perm_i[AP_LSB-1:0]};
endmodule

// File: rtl/dap_ap_decode.sv
module dap_ap_decode #(
  parameter int unsigned AP_W = 2
) (
  input  logic [AP_W-1:0] ap_i,
  input  logic            rd_i,
  input  logic            user_i,
  input  logic            sys_i,
  input  logic            rom_i,
  output logic            allow_o
);
  logic priv;
  assign priv = ~user_i;

  always_comb begin
    unique case (ap_i)
      2'd0:    allow_o = rd_i & ((sys_i & priv) | rom_i);
      2'd1:    allow_o = priv;
      2'd2:    allow_o = rd_i | priv;
      default: allow_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dap_checker.sv
module dap_checker
  import dap_pkg::*;
(
  input  logic [DOM_W-1:0]  dom_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic [1:0]        map_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              rd_i,
  input  logic              user_i,
  input  logic              sys_i,
  input  logic              rom_i,
  input  logic [DACR_W-1:0] dacr_i,
  output logic [1:0]        fault_o,
  output logic [DOM_W-1:0]  dom_o
);
  acc_e            acc;
  map_e            map;
  logic [FLD_W-1:0] ap;
  logic            allow;
  fault_e          fault;

  assign map = map_e'(map_i);

  dap_domain_sel #(.DOM_W(DOM_W), .FLD_W(FLD_W)) u_dom (
    .dacr_i (dacr_i),
    .dom_i  (dom_i),
    .acc_o  (acc)
  );

  dap_ap_sel #(.VA_W(VA_W), .PERM_W(PERM_W), .AP_W(FLD_W)) u_ap (
    .perm_i (perm_i),
    .map_i  (map),
    .va_i   (va_i),
    .ap_o   (ap)
  );

  dap_ap_decode #(.AP_W(FLD_W)) u_dec (
    .ap_i    (ap),
    .rd_i    (rd_i),
    .user_i  (user_i),
    .sys_i   (sys_i),
    .rom_i   (rom_i),
    .allow_o (allow)
  );

  always_comb begin
    unique case (acc)
      ACC_MANAGER: fault = FLT_NONE;
      ACC_CLIENT:  fault = allow ? FLT_NONE
                         : (map == MAP_SECTION) ? FLT_SECT_PERM : FLT_SUB_PERM;
      default:     fault = FLT_DOMAIN;
    endcase
  end

  assign fault_o = fault;
  assign dom_o   = dom_i;
endmodule

// File: rtl/dap_checker_sva.sv
module dap_checker_sva
  import dap_pkg::*;
(
  input logic [DOM_W-1:0]  dom_i,
  input logic [PERM_W-1:0] perm_i,
  input logic [1:0]        map_i,
  input logic [VA_W-1:0]   va_i,
  input logic              rd_i,
  input logic              user_i,
  input logic [DACR_W-1:0] dacr_i,
  input logic [1:0]        fault_o,
  input logic [DOM_W-1:0]  dom_o
);
  logic [1:0] fld;
  logic [1:0] slot;
  logic [1:0] ap;
  assign fld = dacr_i[2*dom_i +: 2];
  always_comb begin
    case (map_i)
      2'd0:    slot = va_i[11:10];
      2'd1:    slot = va_i[15:14];
      2'd2:    slot = 2'd3;
      default: slot = 2'd0;
    endcase
  end
  assign ap = perm_i[4 + 2*slot +: 2];

  always_comb begin
    assert_dom_echo_R10: assert (dom_o == dom_i);
    if (fld == 2'd0 || fld == 2'd2)
      assert_domain_fault_R2: assert (fault_o == 2'd1);
    if (fld == 2'd3)
      assert_manager_pass_R3: assert (fault_o == 2'd0);
    if (fld == 2'd1 && ap == 2'd3)
      assert_ap3_pass_R8: assert (fault_o == 2'd0);
    if (fld == 2'd1 && ap != 2'd3 && ap != 2'd0 && user_i && !rd_i)
      assert_user_write_denied_R6: assert (fault_o != 2'd0);
    if (fault_o == 2'd2)
      assert_sect_kind_R9: assert (map_i == 2'd2);
    if (fault_o == 2'd3)
      assert_sub_kind_R9: assert (map_i != 2'd2);
  end
endmodule

bind dap_checker dap_checker_sva u_sva (
  .dom_i   (dom_i),
  .perm_i  (perm_i),
  .map_i   (map_i),
  .va_i    (va_i),
  .rd_i    (rd_i),
  .user_i  (user_i),
  .dacr_i  (dacr_i),
  .fault_o (fault_o),
  .dom_o   (dom_o)
);

// File: tb/sim_dap_checker.sv
`timescale 1ns/1ps
module sim_dap_checker;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  dom;
  logic [11:0] perm;
  logic [1:0]  map;
  logic [31:0] va;
  logic        rd, user, sys, rom;
  logic [31:0] dacr;
  logic [1:0]  fault;
  logic [3:0]  dom_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  dap_checker u0 (
    .dom_i(dom), .perm_i(perm), .map_i(map), .va_i(va),
    .rd_i(rd), .user_i(user), .sys_i(sys), .rom_i(rom),
    .dacr_i(dacr), .fault_o(fault), .dom_o(dom_out)
  );

  function automatic logic ref_allow(input logic [1:0] a, input logic r, input logic u,
                                     input logic s, input logic m);
    case (a)
      2'd0: return r && ((s && !u) || m);
      2'd1: return !u;
      2'd2: return r || !u;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [1:0] ref_fault();
    logic [1:0] f, sl, a;
    f = 2'((dacr >> (2*dom)) & 32'd3);
    if (f == 2'd0 || f == 2'd2) return 2'd1;
    if (f == 2'd3) return 2'd0;
    case (map)
      2'd0: sl = va[11:10];
      2'd1: sl = va[15:14];
      2'd2: sl = 2'd3;
      default: sl = 2'd0;
    endcase
    a = 2'((perm >> (4 + 2*sl)) & 12'd3);
    if (ref_allow(a, rd, user, sys, rom)) return 2'd0;
    return (map == 2'd2) ? 2'd2 : 2'd3;
  endfunction

  task automatic check(input string req, input logic [1:0] exp_f);
    @(negedge clk);
    n_chk++;
    if (fault !== exp_f || dom_out !== dom) begin
      n_bad++;
      $display("FAIL %s: fault=%0d dom=%0d expected fault=%0d dom=%0d",
               req, fault, dom_out, exp_f, dom);
    end
  endtask

  task automatic set_in(input logic [3:0] d, input logic [11:0] p, input logic [1:0] m,
                        input logic [31:0] v, input logic r, input logic u,
                        input logic s, input logic o, input logic [31:0] dc);
    dom = d; perm = p; map = m; va = v; rd = r; user = u; sys = s; rom = o; dacr = dc;
  endtask

  // all-zero inputs: domain field 0 -> domain fault (R2), echo (R10)
  task automatic t_reset_state();
    set_in(4'd0, 12'd0, 2'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
    check("R2", 2'd1);
    check("R10", 2'd1);
  endtask

  // lone field per domain (R1), manager vs none (R3, R2), reserved value (R2)
  task automatic t_domain_select();
    for (int d = 0; d < 16; d++) begin
      set_in(4'(d), 12'd0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd3 << (2*d));
      check("R1", 2'd0);
      set_in(4'(d), 12'd0, 2'd0, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, ~(32'd3 << (2*d)));
      check("R1", 2'd1);
      set_in(4'(d), 12'hFF0, 2'd2, 32'd0, 1'b1, 1'b0, 1'b1, 1'b1, 32'd2 << (2*d));
      check("R2", 2'd1);
    end
  endtask

  // manager ignores AP=0 user writes on every mapping (R3)
  task automatic t_manager();
    for (int m = 0; m < 4; m++) begin
      set_in(4'd5, 12'h000, 2'(m), 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 32'd3 << 10);
      check("R3", 2'd0);
    end
  endtask

  // slot choice: exactly one slot holds AP=3, others AP=0; user write (R4)
  task automatic t_slot_select();
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 4; v++) begin
          logic [31:0] a;
          logic [1:0]  want_slot;
          a = 32'(v) << ((m == 1) ? 14 : 10);
          a = a | ((m == 1) ? 32'(~v & 3) << 10 : 32'(~v & 3) << 14);
          want_slot = (m == 0 || m == 1) ? 2'(v) : (m == 2) ? 2'd3 : 2'd0;
          set_in(4'd1, 12'(3 << (4 + 2*s)), 2'(m), a, 1'b0, 1'b1, 1'b0, 1'b0, 32'd1 << 2);
          check("R4", (want_slot == 2'(s)) ? 2'd0 : ((m == 2) ? 2'd2 : 2'd3));
        end
  endtask

  // AP decode against direction, privilege and control bits (R5..R8), fault kind (R9)
  task automatic t_ap_sweep();
    for (int ap = 0; ap < 4; ap++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 16; c++) begin
          logic [11:0] p;
          logic [1:0]  e;
          p = {4{2'(ap)}} << 4;
          set_in(4'd9, p, 2'(m), 32'h0000_C400, c[0], c[1], c[2], c[3], 32'd1 << 18);
          e = ref_fault();
          case (ap)
            0: check("R5", e);
            1: check("R6", e);
            2: check("R7", e);
            default: check("R8", e);
          endcase
          if (e != 2'd0) check("R9", e);
        end
  endtask

  initial begin
    set_in(4'd0, 12'd0, 2'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_domain_select();
    t_manager();
    t_slot_select();
    t_ap_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule